// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Transfer Strobe

This block presents a five-digit BCD result one digit at a time. It drives a shared 4-bit BCD bus and five positive-going digit-select lines, which suits a multiplexed display or a processor that reads the digits one by one. The digits come in already latched on `digits_i`. A one-cycle `eoc_i` pulse marks a finished conversion. When that pulse arrives, the scan restarts at the most significant digit.

After each conversion the block also drives an active-low transfer strobe. It pulses once in the middle of each digit slot, five pulses in all. After the fifth pulse it stays quiet, and the scan keeps cycling, until the next conversion ends. An overrange flag is captured together with `eoc_i`. While the flag is set, the BCD bus reads zero. After the last strobe the digit lines are blanked until `ref_start_i` signals the start of the next reference-integration phase, so the display blinks while the input is out of range.

Top module: `digit_scan_strobe`

## Requirements
- R1: After reset is released, only the D5 drive (`digit_o[4]`) is high, `strobe_n_o` stays high, and no strobe pulse occurs until an `eoc_i` pulse has been seen.
- R2: Digit drives are mutually exclusive. The scan steps D5, D4, D3, D2, D1 (`digit_o` bits 4 down to 0) and wraps from D1 straight back to D5 with no idle cycle.
- R3: The D5 drive stays high for 201 consecutive clocks and every other drive for 200.
- R4: `eoc_i` sampled high at a clock edge makes D5 the driven digit in the very next cycle, with its slot counted from that cycle (index 0), whatever digit was being scanned before.
- R5: After `eoc_i`, `strobe_n_o` goes low in the slot cycle with index 100 of each digit, counted from the cycle its drive rises (index 0). Slot boundaries after `eoc_i` are at cycles 0, 201, 401, 601 and 801, so the strobes fall in cycles 100, 301, 501, 701 and 901. Each pulse lasts only for the low half of the clock.
- R6: Exactly five strobe pulses follow each `eoc_i`. None follows after that, while the scan keeps going.
- R7: `bcd_o` carries the digit whose drive is high, bit 3 to bit 0 weighing 8, 4, 2, 1. Digit Dk is taken from `digits_i[4k-1:4k-4]`, so D1 is in bits 3:0 and D5 in bits 19:16. `bcd_o` changes in the same cycle as the drive.
- R8: When `ovr_i` is high together with `eoc_i`, `bcd_o` reads 0 from the next cycle until `ref_start_i` or the next `eoc_i` clears the condition.
- R9: In overrange, all digit drives go low from the cycle after the fifth strobe cycle. They stay low until the cycle after `ref_start_i` is sampled high. From that cycle the scan, which kept its position, is visible again and `bcd_o` shows data again.
- R10: `ref_start_i` outside an overrange condition has no effect on `digit_o` or `bcd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe low phase follows its low half |
| rst_n | input | 1 | Asynchronous active-low reset |
| digits_i | input | 20 | Latched BCD result, D1 in bits 3:0 up to D5 in bits 19:16 |
| eoc_i | input | 1 | One-cycle end-of-conversion pulse |
| ovr_i | input | 1 | Overrange flag, sampled with `eoc_i` |
| ref_start_i | input | 1 | One-cycle start-of-reference-integration pulse |
| digit_o | output | 5 | Positive-going digit drives, bit 4 = D5 (most significant) |
| bcd_o | output | 4 | BCD bus, weights 8/4/2/1 on bits 3..0 |
| strobe_n_o | output | 1 | Active-low half-clock transfer strobe |

## Verification
The hardest state to reach is the end of overrange blanking. Getting there needs an overrange conversion, about nine hundred clocks of scanning to the fifth strobe, and then a reference-start pulse that lands while the hidden scan sits at a known position. The stimulus counts cycles from the conversion pulse and fires `ref_start_i` at a chosen cycle. That way the digit and BCD value that reappear are known in advance. A second pulse in a normal conversion shows the same input leaves the scan alone.

// File: rtl/digit_scan_pkg.sv
`timescale 1ns/1ps
package digit_scan_pkg;
  localparam int unsigned BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/dss_scan_timer.sv
`timescale 1ns/1ps
module dss_scan_timer #(
  parameter int unsigned NUM_DIGITS   = 5,
  parameter int unsigned DIGIT_CYCLES = 200,
  parameter int unsigned LEAD_EXTRA   = 1,
  localparam int unsigned POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int unsigned CNT_W = $clog2(DIGIT_CYCLES + LEAD_EXTRA + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoc_i,
  output logic [POS_W-1:0] pos_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [POS_W-1:0] TOP_POS   = POS_W'(NUM_DIGITS - 1);
  localparam logic [CNT_W-1:0] LAST_LEAD = CNT_W'(DIGIT_CYCLES + LEAD_EXTRA - 1);
  localparam logic [CNT_W-1:0] LAST_REG  = CNT_W'(DIGIT_CYCLES - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] slot_last;
  logic             slot_end;

  always_comb begin
    slot_last = (pos_q == TOP_POS) ? LAST_LEAD : LAST_REG;
    slot_end  = (cnt_q == slot_last);
    pos_d     = pos_q;
    cnt_d     = cnt_q + CNT_W'(1);
    if (eoc_i) begin
      pos_d = TOP_POS;
      cnt_d = '0;
    end else if (slot_end) begin
      cnt_d = '0;
      pos_d = (pos_q == '0) ? TOP_POS : pos_q - POS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= TOP_POS;
      cnt_q <= '0;
    end else begin
      pos_q <= pos_d;
      cnt_q <= cnt_d;
    end
  end

  assign pos_o = pos_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dss_strobe_seq.sv
`timescale 1ns/1ps
module dss_strobe_seq #(
  parameter int unsigned NUM_DIGITS = 5,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned STROBE_AT  = 100,
  localparam int unsigned LEFT_W = $clog2(NUM_DIGITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoc_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             strobe_cyc_o,
  output logic             last_strobe_o
);
  localparam logic [LEFT_W-1:0] FULL_LOAD = LEFT_W'(NUM_DIGITS);
  localparam logic [CNT_W-1:0]  MID_SLOT  = CNT_W'(STROBE_AT);

  logic [LEFT_W-1:0] left_q, left_d;
  logic              left_en;
  logic              fire;

  always_comb begin
    fire    = (left_q != '0) && (cnt_i == MID_SLOT);
    left_en = eoc_i | fire;
    left_d  = eoc_i ? FULL_LOAD : left_q - LEFT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  assign strobe_cyc_o  = fire;
  assign last_strobe_o = fire && (left_q == LEFT_W'(1));
endmodule

// File: rtl/dss_range_ctrl.sv
`timescale 1ns/1ps
module dss_range_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_i,
  input  logic ovr_i,
  input  logic ref_start_i,
  input  logic last_strobe_i,
  output logic ovr_o,
  output logic blank_o
);
  logic ovr_q, ovr_d, ovr_en;
  logic blank_q, blank_d, blank_en;

  always_comb begin
    ovr_en   = eoc_i | ref_start_i;
    ovr_d    = eoc_i ? ovr_i : 1'b0;
    blank_en = eoc_i | ref_start_i | (last_strobe_i & ovr_q);
    blank_d  = !(eoc_i | ref_start_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q   <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      if (ovr_en)   ovr_q   <= ovr_d;
      if (blank_en) blank_q <= blank_d;
    end
  end

  assign ovr_o   = ovr_q;
  assign blank_o = blank_q;
endmodule

// File: rtl/digit_scan_strobe.sv
`timescale 1ns/1ps
module digit_scan_strobe #(
  parameter int unsigned NUM_DIGITS   = 5,
  parameter int unsigned DIGIT_CYCLES = 200,
  parameter int unsigned LEAD_EXTRA   = 1,
  parameter int unsigned STROBE_AT    = DIGIT_CYCLES / 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic [NUM_DIGITS*digit_scan_pkg::BCD_W-1:0]  digits_i,
  input  logic                                         eoc_i,
  input  logic                                         ovr_i,
  input  logic                                         ref_start_i,
  output logic [NUM_DIGITS-1:0]                        digit_o,
  output logic [digit_scan_pkg::BCD_W-1:0]             bcd_o,
  output logic                                         strobe_n_o
);
  import digit_scan_pkg::*;

  localparam int unsigned POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam int unsigned CNT_W = $clog2(DIGIT_CYCLES + LEAD_EXTRA + 1);

  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] cnt;
  logic             strobe_cyc;
  logic             last_strobe;
  logic             ovr;
  logic             blank;
  bcd_t             dig_arr [NUM_DIGITS];
  bcd_t             sel_bcd;

  dss_scan_timer #(
    .NUM_DIGITS  (NUM_DIGITS),
    .DIGIT_CYCLES(DIGIT_CYCLES),
    .LEAD_EXTRA  (LEAD_EXTRA)
  ) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .eoc_i(eoc_i),
    .pos_o(pos),
    .cnt_o(cnt)
  );

  dss_strobe_seq #(
    .NUM_DIGITS(NUM_DIGITS),
    .CNT_W     (CNT_W),
    .STROBE_AT (STROBE_AT)
  ) strobe_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .eoc_i        (eoc_i),
    .cnt_i        (cnt),
    .strobe_cyc_o (strobe_cyc),
    .last_strobe_o(last_strobe)
  );

  dss_range_ctrl range_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .eoc_i        (eoc_i),
    .ovr_i        (ovr_i),
    .ref_start_i  (ref_start_i),
    .last_strobe_i(last_strobe),
    .ovr_o        (ovr),
    .blank_o      (blank)
  );

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign dig_arr[g] = bcd_t'(digits_i[g*BCD_W +: BCD_W]);
    assign digit_o[g] = (pos == POS_W'(g)) && !blank;
  end

  always_comb begin
    sel_bcd = '0;
    for (int k = 0; k < NUM_DIGITS; k++) begin
      if (pos == POS_W'(k)) sel_bcd = dig_arr[k];
    end
  end

  assign bcd_o      = ovr ? '0 : sel_bcd;
  // low only during the low half of the strobe cycle
  assign strobe_n_o = !(strobe_cyc && !clk);
endmodule

// File: rtl/digit_scan_strobe_chk.sv
`timescale 1ns/1ps
module digit_scan_strobe_chk #(
  parameter int unsigned NUM_DIGITS = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  eoc_i,
  input logic [NUM_DIGITS-1:0] digit_o,
  input logic [3:0]            bcd_o,
  input logic                  strobe_n_o
);
  localparam logic [NUM_DIGITS-1:0] TOPBIT = NUM_DIGITS'(1) << (NUM_DIGITS - 1);

  logic [3:0] strobes_seen;

  // sampled at the rising edge, strobe_n_o shows the previous low half
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobes_seen <= '0;
    end else if (eoc_i) begin
      strobes_seen <= '0;
    end else if (!strobe_n_o && strobes_seen != 4'hF) begin
      strobes_seen <= strobes_seen + 4'd1;
    end
  end

  p_onehot_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_o));

  p_scan_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(digit_o) != '0 && digit_o != '0 && digit_o != $past(digit_o) && !$past(eoc_i))
    |-> (digit_o == (($past(digit_o) >> 1) | ($past(digit_o[0]) ? TOPBIT : '0))));

  p_eoc_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_i |=> (digit_o == TOPBIT));

  p_strobe_in_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n_o |-> (digit_o != '0));

  p_strobe_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n_o && !eoc_i) |-> (strobes_seen < 4'd5));

  p_blank_zero_bcd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_o == '0) |-> (bcd_o == '0));
endmodule

bind digit_scan_strobe digit_scan_strobe_chk #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .eoc_i     (eoc_i),
  .digit_o   (digit_o),
  .bcd_o     (bcd_o),
  .strobe_n_o(strobe_n_o)
);

// File: tb/digit_scan_strobe_tb_top.sv
`timescale 1ns/1ps
module digit_scan_strobe_tb_top;
  localparam int PER = 20;
  localparam logic [4:0] D5 = 5'b10000, D4 = 5'b01000, D3 = 5'b00100,
                         D2 = 5'b00010, D1 = 5'b00001;
  // {cycle after eoc, expected drive, strobe low in that cycle}
  localparam logic [21:0] VEC [18] = '{
    {16'd0,    D5, 1'b0}, {16'd100,  D5, 1'b1}, {16'd101,  D5, 1'b0},
    {16'd200,  D5, 1'b0}, {16'd201,  D4, 1'b0}, {16'd301,  D4, 1'b1},
    {16'd400,  D4, 1'b0}, {16'd401,  D3, 1'b0}, {16'd501,  D3, 1'b1},
    {16'd601,  D2, 1'b0}, {16'd701,  D2, 1'b1}, {16'd801,  D1, 1'b0},
    {16'd901,  D1, 1'b1}, {16'd1000, D1, 1'b0}, {16'd1001, D5, 1'b0},
    {16'd1101, D5, 1'b0}, {16'd1202, D4, 1'b0}, {16'd1302, D4, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] digits;
  logic        eoc, ovr, ref_start;
  logic [4:0]  digit_o;
  logic [3:0]  bcd_o;
  logic        strobe_n_o;

  int checks = 0, fails = 0, cur = 0, n_strb = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  digit_scan_strobe dut_i (
    .clk(clk), .rst_n(rst_n), .digits_i(digits), .eoc_i(eoc), .ovr_i(ovr),
    .ref_start_i(ref_start), .digit_o(digit_o), .bcd_o(bcd_o), .strobe_n_o(strobe_n_o)
  );

  always @(negedge clk) begin
    #5;
    if (rst_n === 1'b1 && strobe_n_o === 1'b0) n_strb++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [3:0] exp_bcd(input logic [4:0] oh, input logic [19:0] d);
    exp_bcd = 4'h0;
    for (int k = 0; k < 5; k++) if (oh[k]) exp_bcd = d[4*k +: 4];
  endfunction

  task automatic goto(input int c);
    repeat (c - cur) @(posedge clk);
    cur = c;
    #1;
  endtask

  task automatic sample_lo();
    @(negedge clk);
    #5;
  endtask

  task automatic do_eoc(input logic ov);
    @(posedge clk);
    #2 eoc = 1'b1; ovr = ov;
    @(posedge clk);
    #2 eoc = 1'b0; ovr = 1'b0;
    cur = 0;
  endtask

  task automatic pulse_ref(input int c);
    goto(c);
    ref_start = 1'b1;
    @(posedge clk);
    cur = c + 1;
    #2 ref_start = 1'b0;
  endtask

  task automatic check_drive(input string req, input logic [4:0] exp_d, input logic [3:0] exp_b);
    check(digit_o == exp_d, req, "digit_o", digit_o, exp_d);
    check(bcd_o == exp_b, req, "bcd_o", bcd_o, exp_b);
  endtask

  initial begin
    #(PER * 200000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; eoc = 1'b0; ovr = 1'b0; ref_start = 1'b0;
    digits = 20'h93705;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    sample_lo();
    check_drive("R1", D5, 4'h9);
    check(strobe_n_o == 1'b1, "R1", "strobe_n_o", strobe_n_o, 1);
    repeat (400) @(posedge clk);
    check(n_strb == 0, "R1", "strobes before eoc", n_strb, 0);

    // R2 R3 R5 R6 R7 table walk over a normal conversion
    n_strb = 0;
    do_eoc(1'b0);
    foreach (VEC[i]) begin
      goto(int'(VEC[i][21:6]));
      #4;
      check(strobe_n_o == 1'b1, "R5", "strobe_n_o high half", strobe_n_o, 1);
      sample_lo();
      check_drive("R2/R3/R7", VEC[i][5:1], exp_bcd(VEC[i][5:1], digits));
      check(strobe_n_o == !VEC[i][0], "R5/R6", "strobe_n_o low half", strobe_n_o, !VEC[i][0]);
    end
    check(n_strb == 5, "R6", "strobes per conversion", n_strb, 5);

    // R10 ref start without overrange: offset 350 of period 1001 is D4
    pulse_ref(1350);
    sample_lo();
    check_drive("R10", D4, 4'h3);

    // R4 restart mid scan with new digits
    digits = 20'h18264;
    n_strb = 0;
    do_eoc(1'b0);
    sample_lo();
    check_drive("R4", D5, 4'h1);
    goto(150);
    sample_lo();
    check(n_strb == 1, "R4", "strobes after restart", n_strb, 1);

    // R8 R9 overrange
    n_strb = 0;
    do_eoc(1'b1);
    sample_lo();
    check_drive("R8", D5, 4'h0);
    goto(901);
    sample_lo();
    check(strobe_n_o == 1'b0, "R9", "fifth strobe", strobe_n_o, 0);
    check_drive("R9", D1, 4'h0);
    goto(902);
    sample_lo();
    check_drive("R9", 5'b0, 4'h0);
    goto(1500);
    sample_lo();
    check_drive("R9", 5'b0, 4'h0);
    pulse_ref(1600);
    sample_lo();
    check_drive("R9", D3, 4'h2);
    goto(1602);
    sample_lo();
    check_drive("R2", D2, 4'h6);
    check(n_strb == 5, "R6", "strobes in overrange", n_strb, 5);

    finish_run();
  end
endmodule